// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital control core of a plug-in card's hot-swap power manager. It watches two active-low insertion inputs, a power-enable line from the host, a static strap that picks the monitored supply set, per-supply "above trip level" comparator flags and an over-current comparator flag. From these it drives the high-side gate enable, an active-low driver-on status, a latched active-low fault output, an active-low healthy output and a reset request. The open-drain pins of a real part are modelled here as active-low logic. The analog comparators, the gate charge pump and the slew control are outside the block, and the reset pulse timing lives in a separate block.

The insertion and enable inputs pass through a two-flop synchronizer. The synchronized inputs then drive a five-state machine:
- OFF: power is off and a reset is requested.
- WAIT_INSERT: the host has enabled power and the machine waits for full insertion.
- RAMP: the gates are on and the supplies are rising.
- ON: the supplies are up.
- FAULT: the breaker has tripped.

The transitions are:
- OFF→WAIT_INSERT when the enable is high.
- WAIT_INSERT→RAMP when both insertion inputs are low.
- RAMP→ON when the monitored supplies are good.
- RAMP/ON→FAULT on over-current.
- RAMP/ON→OFF on a loss of insertion.
- WAIT_INSERT/RAMP/ON/FAULT→OFF when the enable is low.

A tripped breaker clears only when the host takes the enable low and then high again.

Top module: `hotswap_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `gate_en`=0, `drv_on_n`=1, `fault_n`=1 and `rst_req`=1 (state OFF).
- R2: `gate_en` rises only when both `brd_sel_a_n` and `brd_sel_b_n` are low (synchronized) together with `host_en` high. With only one of them low, the gates stay off.
- R3: When `host_en` is low, `gate_en` is 0 and `rst_req` is 1.
- R4: When `oc_trip` is 1 while the gates are on, `gate_en` falls and `fault_n` goes to 0 on the next clock edge. Both stay that way after `oc_trip` returns to 0, and also when the insertion inputs change.
- R5: A latched fault clears only after `host_en` goes low and then high. `fault_n` returns to 1 in exactly the cycle in which `gate_en` returns to 1.
- R6: `drv_on_n` is always the inverse of `gate_en`.
- R7: `healthy_n` is 0 exactly when every monitored supply flag is 1. Bit 0 of `sup_ok` is the 3.3 V flag and bit 1 is the 5 V flag. With `sup_sel`=0 both bits are monitored (5 V or mixed mode). With `sup_sel`=1 only bit 0 is monitored.
- R8: A change on `host_en` or an insertion input reaches the state machine through two synchronizer flops. A drop of `host_en` turns `gate_en` off after the third rising clock edge. A rise of `host_en` with the card inserted turns `gate_en` on after the fourth edge.
- R9: When either insertion input goes high while the gates are on, the gates turn off and `fault_n` stays 1. With the enable still high, the machine waits for reinsertion and powers up again once both inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brd_sel_a_n | input | 1 | First insertion detect, active low |
| brd_sel_b_n | input | 1 | Second insertion detect, active low |
| host_en | input | 1 | Host power enable, active high |
| sup_sel | input | 1 | Static monitor select: 0 = 5 V/mixed, 1 = 3.3 V only |
| sup_ok | input | NUM_SUP | Supply-above-trip flags (bit 0 = 3.3 V, bit 1 = 5 V) |
| oc_trip | input | 1 | Over-current comparator flag |
| gate_en | output | 1 | High-side gate drive enable |
| drv_on_n | output | 1 | Driver-on status, active low |
| fault_n | output | 1 | Latched breaker fault, active low |
| healthy_n | output | 1 | Monitored supplies valid, active low |
| rst_req | output | 1 | Card reset request, active high |

## Verification
A wrong state register shows up directly at the ports. A machine stuck in FAULT keeps `fault_n` low after an enable cycle. A missed return to OFF leaves `gate_en` high and `rst_req` low three cycles after the enable drops. A lost fault latch raises `fault_n` while the gates are still off. The bench samples every output a few cycles after each stimulus and also edge by edge around the synchronizer and the fault clear. A state error therefore appears within one to four cycles of the event that exposes it.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_WAIT_INSERT = 3'd1,
        ST_RAMP        = 3'd2,
        ST_ON          = 3'd3,
        ST_FAULT       = 3'd4
    } hsw_state_e;

endpackage

// File: rtl/hsw_sync.sv
// Multi-bit, multi-stage synchronizer with per-bit reset values.
module hsw_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/hsw_supply_mon.sv
// Picks the monitored supply set from the static strap and reduces the flags.
module hsw_supply_mon #(
    parameter int                 NUM_SUP  = 2,
    parameter logic [NUM_SUP-1:0] MASK_MIX = '1,
    parameter logic [NUM_SUP-1:0] MASK_LOW = NUM_SUP'(1)
) (
    input  logic [NUM_SUP-1:0] sup_ok,
    input  logic               sup_sel,
    output logic               all_good
);

    logic [NUM_SUP-1:0] mask;
    logic [NUM_SUP-1:0] covered;

    always_comb begin
        mask     = sup_sel ? MASK_LOW : MASK_MIX;
        covered  = sup_ok | ~mask;
        all_good = &covered;
    end

endmodule

// File: rtl/hsw_fsm.sv
// Power sequencing state machine with breaker latch.
module hsw_fsm
    import hsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       sel_a_s,
    input  logic       sel_b_s,
    input  logic       supply_good,
    input  logic       oc_trip,
    output hsw_state_e state_q,
    output logic       gate_en,
    output logic       fault_n,
    output logic       rst_req
);

    hsw_state_e state_d;
    logic       fault_q;
    logic       fault_d;
    logic       inserted;

    assign inserted = !sel_a_s && !sel_b_s;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_s) state_d = ST_WAIT_INSERT;
            end
            ST_WAIT_INSERT: begin
                if (!en_s)         state_d = ST_OFF;
                else if (inserted) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (!en_s)            state_d = ST_OFF;
                else if (!inserted)   state_d = ST_OFF;
                else if (oc_trip)     state_d = ST_FAULT;
                else if (supply_good) state_d = ST_ON;
            end
            ST_ON: begin
                if (!en_s)          state_d = ST_OFF;
                else if (!inserted) state_d = ST_OFF;
                else if (oc_trip)   state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (!en_s) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
        // Fault is set on entering FAULT and held until the gates reopen.
        fault_d = (state_d == ST_FAULT) || (fault_q && (state_d != ST_RAMP));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    // Output decode
    always_comb begin
        gate_en = (state_q == ST_RAMP) || (state_q == ST_ON);
        rst_req = (state_q == ST_OFF);
        fault_n = !fault_q;
    end

endmodule

// File: rtl/hotswap_seq_ctrl.sv
module hotswap_seq_ctrl
    import hsw_pkg::*;
#(
    parameter int NUM_SUP     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               brd_sel_a_n,
    input  logic               brd_sel_b_n,
    input  logic               host_en,
    input  logic               sup_sel,
    input  logic [NUM_SUP-1:0] sup_ok,
    input  logic               oc_trip,
    output logic               gate_en,
    output logic               drv_on_n,
    output logic               fault_n,
    output logic               healthy_n,
    output logic               rst_req
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_out;
    logic              en_s;
    logic              sel_a_s;
    logic              sel_b_s;
    logic              supply_good;
    hsw_state_e        state_q;

    assign raw_in = {host_en, brd_sel_b_n, brd_sel_a_n};

    // Insertion inputs reset to "removed", enable resets to "off".
    hsw_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .q_out (sync_out)
    );

    assign sel_a_s = sync_out[0];
    assign sel_b_s = sync_out[1];
    assign en_s    = sync_out[2];

    hsw_supply_mon #(
        .NUM_SUP (NUM_SUP)
    ) u_mon (
        .sup_ok   (sup_ok),
        .sup_sel  (sup_sel),
        .all_good (supply_good)
    );

    hsw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_s        (en_s),
        .sel_a_s     (sel_a_s),
        .sel_b_s     (sel_b_s),
        .supply_good (supply_good),
        .oc_trip     (oc_trip),
        .state_q     (state_q),
        .gate_en     (gate_en),
        .fault_n     (fault_n),
        .rst_req     (rst_req)
    );

    assign drv_on_n  = !gate_en;
    assign healthy_n = !supply_good;

endmodule

// File: rtl/hsw_checker.sv
module hsw_checker
    import hsw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en_s,
    input logic       sel_a_s,
    input logic       sel_b_s,
    input logic       oc_trip,
    input hsw_state_e state_q,
    input logic       gate_en,
    input logic       fault_n,
    input logic       rst_req
);

    assert_gate_needs_insert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(!sel_a_s && !sel_b_s && en_s));

    assert_enable_low_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!gate_en && rst_req));

    assert_trip_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && oc_trip && en_s && !sel_a_s && !sel_b_s) |=> (!gate_en && !fault_n));

    assert_fault_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && en_s) |=> !fault_n);

    assert_fault_clear_with_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> $rose(gate_en));

    assert_removal_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && fault_n && en_s && (sel_a_s || sel_b_s)) |=> (!gate_en && fault_n));

endmodule

bind hotswap_seq_ctrl hsw_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (en_s),
    .sel_a_s (sel_a_s),
    .sel_b_s (sel_b_s),
    .oc_trip (oc_trip),
    .state_q (state_q),
    .gate_en (gate_en),
    .fault_n (fault_n),
    .rst_req (rst_req)
);

// File: tb/sim_hotswap_seq_ctrl.sv
`timescale 1ns/1ps
module sim_hotswap_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_a_n = 1'b1;
    logic       sel_b_n = 1'b1;
    logic       en = 1'b0;
    logic       vsel = 1'b0;
    logic [1:0] sup = 2'b00;
    logic       oc = 1'b0;
    logic       gate_en, drv_on_n, fault_n, healthy_n, rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hotswap_seq_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .brd_sel_a_n (sel_a_n),
        .brd_sel_b_n (sel_b_n),
        .host_en     (en),
        .sup_sel     (vsel),
        .sup_ok      (sup),
        .oc_trip     (oc),
        .gate_en     (gate_en),
        .drv_on_n    (drv_on_n),
        .fault_n     (fault_n),
        .healthy_n   (healthy_n),
        .rst_req     (rst_req)
    );

    // {sel_a_n, sel_b_n, en, vsel, sup[1:0], oc, exp gate, drv_n, fault_n, healthy_n, rst_req}
    localparam int NV = 16;
    localparam logic [11:0] VEC [NV] = '{
        12'b1_1_0_0_00_0_0_1_1_1_1, // 0  OFF                        R3
        12'b1_1_1_0_00_0_0_1_1_1_0, // 1  WAIT_INSERT                R2
        12'b0_1_1_0_00_0_0_1_1_1_0, // 2  one select only            R2
        12'b0_0_1_0_00_0_1_0_1_1_0, // 3  RAMP                       R2
        12'b0_0_1_0_01_0_1_0_1_1_0, // 4  mixed needs both           R7
        12'b0_0_1_0_11_0_1_0_1_0_0, // 5  ON, healthy                R7
        12'b0_0_1_1_01_0_1_0_1_0_0, // 6  3.3 V only                 R7
        12'b0_0_1_1_10_0_1_0_1_1_0, // 7  3.3 V missing              R7
        12'b0_0_1_0_11_1_0_1_0_0_0, // 8  over-current               R4
        12'b0_0_1_0_11_0_0_1_0_0_0, // 9  latched                    R4
        12'b1_1_1_0_11_0_0_1_0_0_0, // 10 removal in FAULT           R4
        12'b0_0_0_0_11_0_0_1_0_0_1, // 11 enable low                 R3
        12'b0_0_1_0_11_0_1_0_1_0_0, // 12 re-enable clears           R5
        12'b1_0_1_0_11_0_0_1_1_0_0, // 13 removal, no fault          R9
        12'b0_0_1_0_11_0_1_0_1_0_0, // 14 reinsertion                R9
        12'b0_0_0_0_11_0_0_1_1_0_1  // 15 enable low                 R3
    };

    function automatic string vec_tag(input int i);
        case (i)
            1, 2, 3:    return "R2";
            4, 5, 6, 7: return "R7";
            8, 9, 10:   return "R4";
            12:         return "R5";
            13, 14:     return "R9";
            default:    return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {gate,drv_n,fault_n,healthy_n,rst_req} actual=%b expected=%b",
                     tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {gate_en, drv_on_n, fault_n, healthy_n, rst_req};
    endfunction

    task automatic check_drv();
        checks++;
        if (drv_on_n !== !gate_en) begin
            errors++;
            $display("FAIL R6: drv_on_n actual=%b expected=%b", drv_on_n, !gate_en);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        bit prev_fault_n;
        bit seen;
        // R1: outputs during reset
        @(negedge clk);
        check("R1", outs(), 5'b0_1_1_1_1);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R1", outs(), 5'b0_1_1_1_1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            {sel_a_n, sel_b_n, en, vsel, sup, oc} = VEC[i][11:5];
            tick(6);
            check(vec_tag(i), outs(), VEC[i][4:0]);
            check_drv();
        end

        // R8: enable rise reaches the gates after the fourth edge
        sel_a_n = 1'b0; sel_b_n = 1'b0; sup = 2'b11; vsel = 1'b0;
        en = 1'b1;
        tick(3);
        check("R8", {4'b0, gate_en}, 5'b0);
        tick(1);
        check("R8", {4'b0, gate_en}, 5'b1);
        tick(3);

        // R8/R3: enable drop turns gates off after the third edge
        en = 1'b0;
        tick(2);
        check("R8", {4'b0, gate_en}, 5'b1);
        tick(1);
        check("R3", {3'b0, gate_en, rst_req}, 5'b0_0_0_0_1);

        // R4/R5: trip, enable cycle, fault clears in same cycle gates reopen
        en = 1'b1;
        tick(6);
        oc = 1'b1;
        tick(1);
        oc = 1'b0;
        check("R4", {3'b0, gate_en, fault_n}, 5'b0);
        tick(4);
        check("R4", {3'b0, gate_en, fault_n}, 5'b0);
        en = 1'b0;
        tick(5);
        en = 1'b1;
        prev_fault_n = fault_n;
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (!seen && gate_en) begin
                seen = 1'b1;
                check("R5", {3'b0, prev_fault_n, fault_n}, 5'b0_0_0_0_1);
            end
            if (!seen && fault_n) check("R5", {4'b0, fault_n}, 5'b0);
            prev_fault_n = fault_n;
        end
        checks++;
        if (!seen) begin
            errors++;
            $display("FAIL R5: gate_en actual=0 expected=1 after enable cycle");
        end

        // R1: reset while powered
        rst_n = 1'b0;
        tick(1);
        check("R1", outs(), {2'b01, 1'b1, healthy_n, 1'b1});
        rst_n = 1'b1;
        tick(1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule